// File: doc/BRIEF.md
# I2C Master Arbitration-Loss Monitor

This block sits beside the bit engine of an I2C master. Each clock it compares the values the master drives onto SDA and SCL with the values sampled on the bus, using the current transfer phase that the bit engine reports. It decides whether the master has lost the bus. The watched phases are address, extension code, data, acknowledge, repeated-start generation and stop-generation. A start or stop condition that appears while a byte is in flight also counts as a loss.

On a loss the block tells the bit engine to release both lines at once, in the same cycle. It latches a lost flag and a 3-bit cause code, and both stay until software clears them. It then raises a single-cycle interrupt at a moment that depends on the kind of loss and on two configuration bits. For a mismatch inside a byte, the interrupt comes at the 8th or 9th SCL falling edge of that byte. For a loss caused by a bus condition, the interrupt comes when a stop condition is seen, and only if stop interrupts are enabled.

Top module: `i2c_arb_monitor`

## Requirements
- R1: While reset is low at a clock edge, `arb_lost`, `lost_code` and `irq` are 0 after that edge.
- R2: In phases address (1), extension (2), data (3) and acknowledge (4), a clash is SCL sampled high, SDA released (`sda_drv`=1) and SDA sampled 0. A clash sets `arb_lost` after the edge, and `lost_code` equals the phase number.
- R3: No loss is flagged in idle phase (0), while `scl_in` is 0 with `scl_drv` 0, or while the master drives SDA low itself.
- R4: In phases 1 to 4, `start_det` gives code 5 and `stop_det` gives code 6. A stop takes precedence over a start in the same cycle.
- R5: In repeated-start generation (phase 5), code 7 is set by any of three causes: an SDA clash, a `stop_det`, or SCL sampled 0 while `scl_drv` is 1.
- R6: In stop generation (phase 6), an SDA clash gives code 7.
- R7: `drive_release` is 1 in the same cycle that a loss is seen, and stays 1 while `arb_lost` is 1.
- R8: Flag and code hold until `clr` is pulsed. Later clashes do not change the code. After `clr` both read 0.
- R9: For codes 1 to 4, `irq` pulses on the cycle after the first `scl_fall` whose `bit_cnt` is at least 9 when `wait9`=1, or at least 8 when `wait9`=0.
- R10: For codes 5 to 7, `irq` pulses on the cycle after a `stop_det`, including the stop that caused the loss, but only if `stop_ie`=1. With `stop_ie`=0 no pulse ever comes.
- R11: `irq` lasts one cycle, occurs only while `arb_lost` is 1, and fires at most once per loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 3 | Transfer phase from the bit engine (0 idle, 1 addr, 2 ext, 3 data, 4 ack, 5 restart gen, 6 stop gen) |
| bit_cnt | input | CNT_W | SCL clock index within the byte |
| scl_fall | input | 1 | Strobe: SCL falling edge seen this cycle |
| start_det | input | 1 | Strobe: start/restart condition on the bus |
| stop_det | input | 1 | Strobe: stop condition on the bus |
| sda_in | input | 1 | Sampled SDA |
| scl_in | input | 1 | Sampled SCL |
| sda_drv | input | 1 | Master SDA drive (1 = released) |
| scl_drv | input | 1 | Master SCL drive (1 = released) |
| wait9 | input | 1 | Byte-loss interrupt at the 9th edge (1) or from the 8th edge on (0) |
| stop_ie | input | 1 | Enable interrupt on stop condition |
| clr | input | 1 | Clear lost flag, code and pending interrupt |
| arb_lost | output | 1 | Arbitration-lost flag |
| lost_code | output | 3 | Cause code (0 none, 1-4 byte phase, 5 start seen, 6 stop seen, 7 during condition generation) |
| drive_release | output | 1 | Release SDA and SCL drive |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The hardest case to reach is an acknowledge-phase loss with `wait9`=0. Here the clash appears after the 8th edge, the earliest target, has already gone by, so the interrupt must move to the 9th edge. The bench sweeps every byte phase under both `wait9` settings. It injects the clash either early in the byte or only at the 9th bit, then walks `scl_fall` edges and expects the pulse at the first edge at or past the target. Condition-caused losses are run with `stop_ie` both on and off. After each pulse the bench sends more stops and edges to confirm that no second pulse appears.

// File: rtl/arb_pkg.sv
// Shared types for the arbitration monitor.
// Assumes the bit engine encodes phases as listed in phase_e.
package arb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_EXT     = 3'd2,
        PH_DATA    = 3'd3,
        PH_ACK     = 3'd4,
        PH_RSTART  = 3'd5,
        PH_STOPGEN = 3'd6
    } phase_e;

    typedef enum logic [2:0] {
        LC_NONE       = 3'd0,
        LC_ADDR       = 3'd1,
        LC_EXT        = 3'd2,
        LC_DATA       = 3'd3,
        LC_ACK        = 3'd4,
        LC_START_SEEN = 3'd5,
        LC_STOP_SEEN  = 3'd6,
        LC_COND_GEN   = 3'd7
    } lcode_e;
endpackage

// File: rtl/arb_detect.sv
// Combinational loss detector. It compares drive and sample values
// for the current phase and produces a loss strobe and a cause code.
// Assumes sda_in/scl_in are already synchronised and the condition
// strobes last exactly one cycle.
module arb_detect
    import arb_pkg::*;
(
    input  phase_e phase,
    input  logic   sda_in,
    input  logic   scl_in,
    input  logic   sda_drv,
    input  logic   scl_drv,
    input  logic   start_det,
    input  logic   stop_det,
    output logic   loss_now,
    output lcode_e loss_code,
    output logic   loss_is_cond
);
    logic sda_clash;
    logic scl_clash;

    assign sda_clash = scl_in & sda_drv & ~sda_in;
    assign scl_clash = scl_drv & ~scl_in;

    // Pick the cause for the current phase; a stop outranks a start.
    always_comb begin
        loss_now  = 1'b0;
        loss_code = LC_NONE;
        unique case (phase)
            PH_ADDR, PH_EXT, PH_DATA, PH_ACK: begin
                if (stop_det) begin
                    loss_now  = 1'b1;
                    loss_code = LC_STOP_SEEN;
                end else if (start_det) begin
                    loss_now  = 1'b1;
                    loss_code = LC_START_SEEN;
                end else if (sda_clash) begin
                    loss_now  = 1'b1;
                    loss_code = lcode_e'(phase);
                end
            end
            PH_RSTART: begin
                if (sda_clash || scl_clash || stop_det) begin
                    loss_now  = 1'b1;
                    loss_code = LC_COND_GEN;
                end
            end
            PH_STOPGEN: begin
                if (sda_clash) begin
                    loss_now  = 1'b1;
                    loss_code = LC_COND_GEN;
                end
            end
            default: begin
                loss_now  = 1'b0;
                loss_code = LC_NONE;
            end
        endcase
    end

    // Codes from 5 upward are condition-caused and wait for a stop.
    assign loss_is_cond = loss_now && (loss_code >= LC_START_SEEN);
endmodule

// File: rtl/arb_irq_timer.sv
// Interrupt timer. It keeps one pending request per loss and fires
// it either on the chosen SCL falling edge of the byte or on a stop
// condition. Assumes new_loss is asserted at most once between clears.
module arb_irq_timer #(
    parameter int CNT_W     = 4,
    parameter int BYTE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             new_loss,
    input  logic             new_is_cond,
    input  logic             scl_fall,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             stop_det,
    input  logic             wait9,
    input  logic             stop_ie,
    output logic             irq
);
    localparam int EARLY_EDGE = BYTE_BITS;
    localparam int LATE_EDGE  = BYTE_BITS + 1;

    logic             pend_byte;
    logic             pend_cond;
    logic [CNT_W-1:0] target;
    logic             byte_hit;
    logic             cond_hit;
    logic             fire;

    assign target   = wait9 ? CNT_W'(LATE_EDGE) : CNT_W'(EARLY_EDGE);
    assign byte_hit = pend_byte && scl_fall && (bit_cnt >= target);
    assign cond_hit = (pend_cond || (new_loss && new_is_cond)) && stop_det && stop_ie;
    assign fire     = byte_hit || cond_hit;

    // Track which kind of request is waiting for its firing point.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || fire) begin
            pend_byte <= 1'b0;
            pend_cond <= 1'b0;
        end else if (new_loss) begin
            pend_byte <= ~new_is_cond;
            pend_cond <= new_is_cond;
        end
    end

    // Register the pulse so that it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire && !clr;
    end
endmodule

// File: rtl/i2c_arb_monitor.sv
// Top of the arbitration monitor. It holds the lost flag and cause
// code, drives the release request and hosts the interrupt timer.
// Assumes clr is a one-cycle software strobe.
module i2c_arb_monitor
    import arb_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BYTE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       phase,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             sda_drv,
    input  logic             scl_drv,
    input  logic             wait9,
    input  logic             stop_ie,
    input  logic             clr,
    output logic             arb_lost,
    output logic [2:0]       lost_code,
    output logic             drive_release,
    output logic             irq
);
    logic   loss_now;
    lcode_e loss_code;
    logic   loss_is_cond;
    logic   loss_evt;
    logic   lost_q;
    lcode_e code_q;

    arb_detect i_detect (
        .phase        (phase_e'(phase)),
        .sda_in       (sda_in),
        .scl_in       (scl_in),
        .sda_drv      (sda_drv),
        .scl_drv      (scl_drv),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .loss_now     (loss_now),
        .loss_code    (loss_code),
        .loss_is_cond (loss_is_cond)
    );

    // Only the first loss since the last clear counts as an event.
    assign loss_evt = loss_now && !lost_q && !clr;

    // Latch flag and cause on the first loss; hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lost_q <= 1'b0;
            code_q <= LC_NONE;
        end else if (loss_evt) begin
            lost_q <= 1'b1;
            code_q <= loss_code;
        end
    end

    arb_irq_timer #(
        .CNT_W     (CNT_W),
        .BYTE_BITS (BYTE_BITS)
    ) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .new_loss    (loss_evt),
        .new_is_cond (loss_is_cond),
        .scl_fall    (scl_fall),
        .bit_cnt     (bit_cnt),
        .stop_det    (stop_det),
        .wait9       (wait9),
        .stop_ie     (stop_ie),
        .irq         (irq)
    );

    assign arb_lost      = lost_q;
    assign lost_code     = code_q;
    assign drive_release = lost_q || loss_now;
endmodule

// File: rtl/i2c_arb_monitor_checker.sv
// Property checker for i2c_arb_monitor, attached through bind.
// Observes only top-level ports.
module i2c_arb_monitor_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       arb_lost,
    input logic [2:0] lost_code,
    input logic       drive_release,
    input logic       irq
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!arb_lost && !irq && lost_code == 3'd0));

    assert_code_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> lost_code != 3'd0);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> drive_release);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !clr) |=> (arb_lost && $stable(lost_code)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!arb_lost && !irq));

    assert_irq_needs_lost_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> arb_lost);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind i2c_arb_monitor i2c_arb_monitor_checker i_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .arb_lost      (arb_lost),
    .lost_code     (lost_code),
    .drive_release (drive_release),
    .irq           (irq)
);

// File: tb/test_i2c_arb_monitor.sv
// Self-checking bench: sweeps phases, wait9 and stop_ie settings.
module test_i2c_arb_monitor;
    logic       clk = 1'b0;
    logic       rst_n, scl_fall, start_det, stop_det;
    logic       sda_in, scl_in, sda_drv, scl_drv, wait9, stop_ie, clr;
    logic [2:0] phase;
    logic [3:0] bit_cnt;
    logic       arb_lost, drive_release, irq;
    logic [2:0] lost_code;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    i2c_arb_monitor i_i2c_arb_monitor (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bit_cnt(bit_cnt),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_in(sda_in), .scl_in(scl_in), .sda_drv(sda_drv), .scl_drv(scl_drv),
        .wait9(wait9), .stop_ie(stop_ie), .clr(clr), .arb_lost(arb_lost),
        .lost_code(lost_code), .drive_release(drive_release), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Quiet bus: everything released and high, no strobes.
    task automatic quiet();
        @(negedge clk);
        sda_in = 1; scl_in = 1; sda_drv = 1; scl_drv = 1;
        scl_fall = 0; start_det = 0; stop_det = 0; clr = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_clear();
        quiet(); clr = 1; tick(); quiet(); phase = 3'd0;
    endtask

    // Walk SCL falling edges from first to 10; expect pulse at exp_cnt only.
    task automatic edges(int first, int exp_cnt, string req);
        for (int c = first; c <= 10; c++) begin
            quiet(); scl_fall = 1; bit_cnt = 4'(c);
            tick();
            chk(req, int'(irq), (c == exp_cnt) ? 1 : 0);
        end
        quiet(); tick();
    endtask

    // Send a stop, expect irq per stop_ie, then a second stop gives none.
    task automatic stop_pulse(bit ie, string req);
        quiet(); phase = 3'd0; stop_det = 1; tick();
        chk(req, int'(irq), ie ? 1 : 0);
        quiet(); stop_det = 1; tick();
        chk("R11", int'(irq), 0);
        quiet(); tick();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; phase = 0; bit_cnt = 0; wait9 = 0; stop_ie = 0;
        quiet(); tick(); tick();
        chk("R1 lost", int'(arb_lost), 0);
        chk("R1 code", int'(lost_code), 0);
        chk("R1 irq", int'(irq), 0);
        quiet(); rst_n = 1; tick();

        // R3: no loss in any phase when SCL low or SDA driven low; idle clash ignored.
        for (int p = 0; p < 7; p++) begin
            quiet(); phase = 3'(p); scl_in = 0; scl_drv = 0; sda_in = 0; tick();
            quiet(); sda_drv = 0; sda_in = 0; tick();
            chk("R3", int'(arb_lost), 0);
        end
        quiet(); phase = 0; sda_in = 0; tick();
        chk("R3 idle", int'(arb_lost), 0);

        // R2/R7/R9/R8: byte-phase clash, early or at bit 9, both wait9 settings.
        for (int p = 1; p <= 4; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int late = 0; late < 2; late++) begin
                    int tgt;
                    int first;
                    wait9 = w[0];
                    first = late ? 9 : 3;
                    tgt = (w == 1) ? 9 : 8;
                    if (first > tgt) tgt = first;
                    quiet(); phase = 3'(p); bit_cnt = 4'(first); sda_in = 0;
                    #1 chk("R7 same cycle", int'(drive_release), 1);
                    tick();
                    chk("R2 flag", int'(arb_lost), 1);
                    chk("R2 code", int'(lost_code), p);
                    edges(first, tgt, "R9");
                    // R8: a later clash in another phase leaves the code.
                    quiet(); phase = 3'(p == 4 ? 1 : 4); sda_in = 0; tick();
                    chk("R8 hold", int'(lost_code), p);
                    chk("R7 hold", int'(drive_release), 1);
                    do_clear();
                    chk("R8 clear flag", int'(arb_lost), 0);
                    chk("R8 clear code", int'(lost_code), 0);
                end
            end
        end

        // R4/R5/R6/R10: condition-caused losses under both stop_ie values.
        for (int ie = 0; ie < 2; ie++) begin
            stop_ie = ie[0];
            for (int k = 0; k < 6; k++) begin
                quiet();
                case (k)
                    0: begin phase = 3; start_det = 1; end
                    1: begin phase = 2; stop_det = 1; start_det = 1; end
                    2: begin phase = 5; sda_in = 0; end
                    3: begin phase = 5; scl_in = 0; end
                    4: begin phase = 5; stop_det = 1; end
                    default: begin phase = 6; sda_in = 0; end
                endcase
                tick();
                chk(k < 2 ? "R4 flag" : (k < 5 ? "R5 flag" : "R6 flag"), int'(arb_lost), 1);
                chk(k < 2 ? "R4 code" : (k < 5 ? "R5 code" : "R6 code"), int'(lost_code),
                    k == 0 ? 5 : (k == 1 ? 6 : 7));
                if (k == 1 || k == 4) begin
                    chk("R10 own stop", int'(irq), ie);
                    quiet(); phase = 0; tick();
                    chk("R11", int'(irq), 0);
                    stop_pulse(1'b0, "R10 no repeat");
                end else begin
                    chk("R10 wait", int'(irq), 0);
                    quiet(); phase = 0; scl_fall = 1; bit_cnt = 9; tick();
                    chk("R10 not on edge", int'(irq), 0);
                    stop_pulse(ie[0], "R10 stop");
                end
                do_clear();
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule